// File: doc/BRIEF.md
# Programmable Divider Timer with Modulo Reload

This block is a small memory-mapped timer built around a 16-bit free-running prescaler clocked by the CPU clock. The upper byte of the prescaler is visible as a divider register. Software can clear it at any time. An 8-bit counter advances on the falling edge of one prescaler bit. That bit is chosen by a two-bit rate field and gated by an enable bit.

When the counter steps past 0xFF, it does not wrap to zero. It takes the value held in a modulo register and raises an interrupt request for one clock. Software sets the overflow period by programming that reload value.

Access is through a byte-wide bus with a two-bit register select and a write strobe. Read data is registered and appears one clock after the select is presented.

Top module: `prog_div_timer`

## Requirements
- R1: During and after synchronous reset the divider, counter, modulo and control state are zero. The control register reads 0xF8, `tmr_irq` is low and `bus_rdata` is 0x00.
- R2: The divider (select 0) equals bits 15:8 of the prescaler. The prescaler increments on every clock, so the divider advances once every 256 clocks.
- R3: A write with select 0 clears the whole prescaler to zero whatever the data. That write never causes a counter increment by itself.
- R4: The counter (select 1) increments on each falling edge of (selected prescaler bit AND control bit 2). Rate code 00 selects bit 9 (÷1024), 01 selects bit 3 (÷16), 10 selects bit 5 (÷64) and 11 selects bit 7 (÷256).
- R5: While control bit 2 is 0, the counter does not change except through bus writes. Clearing bit 2 while the selected bit is 1 counts as one falling edge.
- R6: An increment at counter value 0xFF loads the counter with the modulo value. `tmr_irq` is high for exactly the one clock in which the reloaded value first appears.
- R7: A bus write to the counter takes priority over an increment in the same clock. The written value is stored, and no interrupt is raised.
- R8: Read data is registered: `bus_rdata` shows, one clock later, the register chosen by `bus_sel` (0 divider, 1 counter, 2 modulo, 3 control). Control reads return 1 in bits 7:3 and the stored enable and rate in bits 2:0.
- R9: The modulo register (select 2) holds the last byte written. A reload uses the modulo value held before any write in that same clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | CPU clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 2 | Register select |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| tmr_irq | output | 1 | One-clock overflow interrupt request |

## Verification
A corrupted prescaler bit shows first in the divider readback, or as a counter increment at the wrong spacing. For the fastest rate that takes no more than 16 clocks. A wrong edge detector or a wrong tap choice shifts the moment the counter steps, and the one-cycle read latency exposes that within a clock of the next expected increment. A wrong reload source or a wrong interrupt width shows at the next overflow, as a wrong counter readback or as an interrupt longer than one clock.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  typedef enum logic [1:0] {
    SEL_DIV  = 2'd0,
    SEL_CNT  = 2'd1,
    SEL_MOD  = 2'd2,
    SEL_CTRL = 2'd3
  } tmr_sel_e;

  localparam int CTRL_W  = 3;
  localparam int EN_BIT  = 2;

  // Prescaler bit whose falling edge feeds the counter for each rate code.
  function automatic int tap_of(input logic [1:0] rate);
    case (rate)
      2'b00:   return 9;
      2'b01:   return 3;
      2'b10:   return 5;
      default: return 7;
    endcase
  endfunction
endpackage

// File: rtl/tmr_prescaler.sv
module tmr_prescaler #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clear,
  output logic [W-1:0] presc
);
  always_ff @(posedge clk) begin
    if (rst || clear) presc <= '0;
    else              presc <= presc + 1'b1;
  end
endmodule

// File: rtl/tmr_tick_gen.sv
module tmr_tick_gen #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clear,
  input  logic [W-1:0] presc,
  input  logic [1:0]   rate,
  input  logic         en,
  output logic         tick
);
  import tmr_pkg::*;
  localparam int IW = $clog2(W);

  logic [IW-1:0] tap_idx;
  logic          gated;
  logic          gated_q;

  always_comb begin
    tap_idx = IW'(tap_of(rate));
    gated   = presc[tap_idx] & en;
    tick    = gated_q & ~gated;
  end

  // Clearing with the prescaler keeps a divider write from faking an edge.
  always_ff @(posedge clk) begin
    if (rst || clear) gated_q <= 1'b0;
    else              gated_q <= gated;
  end
endmodule

// File: rtl/tmr_counter.sv
module tmr_counter #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [DW-1:0] load_val,
  input  logic          tick,
  input  logic [DW-1:0] modulo,
  output logic [DW-1:0] cnt,
  output logic          irq
);
  localparam logic [DW-1:0] TOP = '1;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
      irq <= 1'b0;
    end else begin
      irq <= 1'b0;
      if (load) begin
        cnt <= load_val;
      end else if (tick) begin
        if (cnt == TOP) begin
          cnt <= modulo;
          irq <= 1'b1;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/prog_div_timer.sv
module prog_div_timer #(
  parameter int DW      = 8,
  parameter int PRESC_W = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [1:0]    bus_sel,
  input  logic          bus_wr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  output logic          tmr_irq
);
  import tmr_pkg::*;

  logic [PRESC_W-1:0] presc;
  logic [DW-1:0]      div_val;
  logic [DW-1:0]      cnt_q;
  logic [DW-1:0]      mod_q;
  logic [CTRL_W-1:0]  ctrl_q;
  logic               tick;
  logic               wr_div, wr_cnt, wr_mod, wr_ctrl;
  logic [DW-1:0]      rd_mux;

  always_comb begin
    wr_div  = bus_wr && (tmr_sel_e'(bus_sel) == SEL_DIV);
    wr_cnt  = bus_wr && (tmr_sel_e'(bus_sel) == SEL_CNT);
    wr_mod  = bus_wr && (tmr_sel_e'(bus_sel) == SEL_MOD);
    wr_ctrl = bus_wr && (tmr_sel_e'(bus_sel) == SEL_CTRL);
    div_val = presc[PRESC_W-1 -: DW];
  end

  tmr_prescaler #(.W(PRESC_W)) u_presc (
    .clk(clk), .rst(rst), .clear(wr_div), .presc(presc)
  );

  tmr_tick_gen #(.W(PRESC_W)) u_tick (
    .clk(clk), .rst(rst), .clear(wr_div), .presc(presc),
    .rate(ctrl_q[1:0]), .en(ctrl_q[EN_BIT]), .tick(tick)
  );

  tmr_counter #(.DW(DW)) u_cnt (
    .clk(clk), .rst(rst), .load(wr_cnt), .load_val(bus_wdata),
    .tick(tick), .modulo(mod_q), .cnt(cnt_q), .irq(tmr_irq)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      mod_q  <= '0;
      ctrl_q <= '0;
    end else begin
      if (wr_mod)  mod_q  <= bus_wdata;
      if (wr_ctrl) ctrl_q <= bus_wdata[CTRL_W-1:0];
    end
  end

  always_comb begin
    case (tmr_sel_e'(bus_sel))
      SEL_DIV:  rd_mux = div_val;
      SEL_CNT:  rd_mux = cnt_q;
      SEL_MOD:  rd_mux = mod_q;
      default:  rd_mux = {{(DW-CTRL_W){1'b1}}, ctrl_q};
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) bus_rdata <= '0;
    else     bus_rdata <= rd_mux;
  end
endmodule

// File: rtl/tmr_checker.sv
module tmr_checker #(
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst,
  input logic          wr,
  input logic [1:0]    sel,
  input logic [DW-1:0] cnt_val,
  input logic [DW-1:0] mod_val,
  input logic [DW-1:0] div_val,
  input logic          en,
  input logic          irq
);
  logic rst_q;
  always_ff @(posedge clk) rst_q <= rst;

  // R1: interrupt low in the clock after reset is applied
  always_ff @(posedge clk) begin
    if (rst_q) assert (irq == 1'b0) else $error("p_reset_irq_r1");
  end

  p_div_clear_r3: assert property (@(posedge clk) disable iff (rst)
    (wr && sel == 2'd0) |=> (div_val == '0));

  p_div_step_r2: assert property (@(posedge clk) disable iff (rst)
    !(wr && sel == 2'd0) |=>
      (div_val == $past(div_val) || div_val == $past(div_val) + 1'b1));

  p_disabled_hold_r5: assert property (@(posedge clk) disable iff (rst)
    (!en && !$past(en) && !(wr && sel == 2'd1)) |=> $stable(cnt_val));

  p_irq_single_r6: assert property (@(posedge clk) disable iff (rst)
    irq |=> !irq);

  p_reload_value_r6: assert property (@(posedge clk) disable iff (rst)
    irq |-> (cnt_val == $past(mod_val)));

  p_write_wins_r7: assert property (@(posedge clk) disable iff (rst)
    (wr && sel == 2'd1) |=> !irq);
endmodule

bind prog_div_timer tmr_checker #(.DW(DW)) u_chk (
  .clk(clk), .rst(rst), .wr(bus_wr), .sel(bus_sel),
  .cnt_val(cnt_q), .mod_val(mod_q), .div_val(div_val),
  .en(ctrl_q[2]), .irq(tmr_irq)
);

// File: tb/tb_prog_div_timer.sv
`timescale 1ns/1ps
module tb_prog_div_timer;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [1:0] bus_sel = 2'd0;
  logic       bus_wr = 1'b0;
  logic [7:0] bus_wdata = 8'd0;
  logic [7:0] bus_rdata;
  logic       tmr_irq;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  prog_div_timer dut (
    .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .tmr_irq(tmr_irq)
  );

  // Expected-value model built from the requirements.
  logic [15:0] m_presc;
  logic        m_prev;
  logic [7:0]  m_cnt, m_mod, m_rdata;
  logic [2:0]  m_ctrl;
  logic        m_irq;
  logic        m_in, m_tick;

  function automatic int rate_bit(input logic [1:0] r); // R4 encoding
    case (r)
      2'b00: return 9;
      2'b01: return 3;
      2'b10: return 5;
      default: return 7;
    endcase
  endfunction

  function automatic logic [7:0] read_exp(input logic [1:0] s);
    case (s)
      2'd0: return m_presc[15:8];
      2'd1: return m_cnt;
      2'd2: return m_mod;
      default: return {5'b11111, m_ctrl};
    endcase
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_presc <= '0; m_prev <= 1'b0; m_cnt <= '0; m_mod <= '0;
      m_ctrl <= '0; m_irq <= 1'b0; m_rdata <= '0;
    end else begin
      m_in   = m_presc[rate_bit(m_ctrl[1:0])] & m_ctrl[2];
      m_tick = m_prev & ~m_in;
      m_rdata <= read_exp(bus_sel);
      if (bus_wr && bus_sel == 2'd0) begin
        m_presc <= '0; m_prev <= 1'b0;
      end else begin
        m_presc <= m_presc + 1'b1; m_prev <= m_in;
      end
      m_irq <= 1'b0;
      if (bus_wr && bus_sel == 2'd1) m_cnt <= bus_wdata;
      else if (m_tick) begin
        if (m_cnt == 8'hFF) begin m_cnt <= m_mod; m_irq <= 1'b1; end
        else m_cnt <= m_cnt + 1'b1;
      end
      if (bus_wr && bus_sel == 2'd2) m_mod <= bus_wdata;
      if (bus_wr && bus_sel == 2'd3) m_ctrl <= bus_wdata[2:0];
    end
  end

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual %h expected %h at cycle %0d", req, act, exp, cyc);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      fails++;
      checks++;
      $display("FAIL watchdog expired actual %0d expected <150000", cyc);
      finish_run();
    end
  end

  // Continuous comparison against the model, away from the active edge.
  bit cmp_on = 1'b0;
  always @(negedge clk) begin
    if (cmp_on && !rst) begin
      chk("R6 irq", {7'd0, tmr_irq}, {7'd0, m_irq});
      case (m_rdata_sel_q)
        2'd0: chk("R2 R3 divider read", bus_rdata, m_rdata);
        2'd1: chk("R4 R5 R7 counter read", bus_rdata, m_rdata);
        2'd2: chk("R9 modulo read", bus_rdata, m_rdata);
        default: chk("R8 control read", bus_rdata, m_rdata);
      endcase
    end
  end
  logic [1:0] m_rdata_sel_q;
  always @(posedge clk) m_rdata_sel_q <= bus_sel;

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      bus_wr = 1'b0;
    end
  endtask

  task automatic wr(input logic [1:0] s, input logic [7:0] d);
    @(negedge clk);
    bus_sel = s; bus_wr = 1'b1; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] s, output logic [7:0] v);
    @(negedge clk);
    bus_sel = s; bus_wr = 1'b0;
    @(negedge clk);
    v = bus_rdata;
  endtask

  initial begin
    logic [7:0] v;
    int waited;
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    chk("R1 irq in reset", {7'd0, tmr_irq}, 8'd0);
    chk("R1 rdata in reset", bus_rdata, 8'd0);
    rst = 1'b0;
    cmp_on = 1'b1;

    // R1/R8 directed reads after reset
    rd(2'd3, v); chk("R1 R8 control after reset", v, 8'hF8);
    rd(2'd1, v); chk("R1 counter after reset", v, 8'h00);
    rd(2'd2, v); chk("R1 modulo after reset", v, 8'h00);

    // R8/R9 readback of written values
    wr(2'd2, 8'h5A); rd(2'd2, v); chk("R9 modulo write", v, 8'h5A);
    wr(2'd3, 8'h06); rd(2'd3, v); chk("R8 control upper ones", v, 8'hFE);

    // R3: divider clear, then read the next cycle
    idle(700);
    wr(2'd0, 8'hC3); rd(2'd0, v); chk("R3 divider cleared", v, 8'h00);
    // R2: after 600 more clocks the divider is 2
    idle(600);
    rd(2'd0, v); chk("R2 divider after ~600 clocks", v, 8'h02);

    // R5: disabled counter holds
    wr(2'd3, 8'h01); wr(2'd1, 8'h10);
    idle(2000);
    rd(2'd1, v); chk("R5 disabled counter holds", v, 8'h10);

    // R6: overflow at fastest rate reloads modulo with one-clock irq
    wr(2'd2, 8'h40); wr(2'd1, 8'hFF); wr(2'd3, 8'h05);
    waited = 0;
    while (tmr_irq !== 1'b1 && waited < 40) begin
      @(negedge clk); waited++;
    end
    chk("R6 irq seen at fast rate", {7'd0, tmr_irq}, 8'd1);
    rd(2'd1, v); chk("R6 reload value", v, 8'h40);

    // Random mix
    for (int i = 0; i < 60000; i++) begin
      int r;
      @(negedge clk);
      r = $urandom % 100;
      bus_sel = 2'($urandom);
      bus_wdata = 8'($urandom);
      bus_wr = 1'b0;
      if (r < 2) begin
        bus_sel = 2'd3; bus_wr = 1'b1;
        if (($urandom % 4) != 0) bus_wdata[2] = 1'b1;
      end else if (r < 5) begin
        bus_sel = 2'd1; bus_wr = 1'b1; bus_wdata[7:4] = 4'hF;
      end else if (r < 7) begin
        bus_sel = 2'd2; bus_wr = 1'b1;
      end else if (r < 8) begin
        bus_sel = 2'd0; bus_wr = 1'b1;
      end
    end
    idle(4);
    finish_run();
  end
endmodule